// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows a processor through its clock-control power states: Normal, AutoHALT, Stop-Grant, Sleep and Deep Sleep. It runs from an always-on reference clock. It takes three request levels (stop-clock request, halt indication, sleep request) and two clocks that it only watches: the bus clock and the interrupt-controller clock. Each watched clock passes through a synchroniser and an edge detector. The clock counts as stopped once no edge has been seen for `IDLE_LIMIT` reference cycles.

Deep Sleep has no request pin. The block enters it when the bus clock is seen to stop while in Sleep. When the bus clock comes back, the block waits a phase-locked-loop settling interval before it reports Sleep again. That interval is `REF_KHZ * SETTLE_US / 1000` reference cycles, which is 1 ms by default. From its state the block drives the L2 cache clock enable, the snoop-response enable and the interrupt-latch enable. It also raises a sticky flag when the clock-control protocol is broken.

Top module: `lps_sequencer`

## Requirements
- R1: After reset the state output is Normal (code 0), the L2 clock, snoop and interrupt-latch enables are all 1, and the violation flag is 0.
- R2: In Normal, a high halt indication moves the state to AutoHALT (code 1). Dropping it returns the state to Normal. All three enables stay 1 in AutoHALT.
- R3: A high stop-clock request moves Normal or AutoHALT to Stop-Grant (code 2). Dropping the request in Stop-Grant returns the state to Normal. All enables stay 1 in Stop-Grant.
- R4: A high sleep request in Stop-Grant moves the state to Sleep (code 3). Dropping it returns the state to Stop-Grant. In Sleep, snoop and interrupt-latch enables are 0 and the L2 clock enable stays 1.
- R5: In Sleep, once the bus clock shows no edge for `IDLE_LIMIT` reference cycles, the state becomes Deep Sleep (code 4). In Deep Sleep all three enables are 0.
- R6: When the bus clock restarts in Deep Sleep, the block keeps reporting Deep Sleep with the L2 enable at 0 for `REF_KHZ*SETTLE_US/1000` reference cycles. It then reports Sleep with the L2 enable at 1.
- R7: The violation flag is set if the interrupt-controller clock is stopped while in AutoHALT or Stop-Grant.
- R8: Stopping the interrupt-controller clock in Sleep or Deep Sleep does not set the flag, provided it runs again before the bus clock restarts.
- R9: The flag is set if any request input changes in Deep Sleep or during settling, or if the stop-clock request or halt indication changes in Sleep.
- R10: The flag is set if the interrupt-controller clock is not running at the moment the bus clock restart is detected in Deep Sleep.
- R11: Once set, the violation flag stays at 1 until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_i | input | 1 | Stop-clock request level (asynchronous) |
| halt_i | input | 1 | Halt indication level (asynchronous) |
| sleep_req_i | input | 1 | Sleep request level (asynchronous) |
| bus_clk_i | input | 1 | Bus clock, watched for activity |
| irq_clk_i | input | 1 | Interrupt-controller clock, watched for activity |
| state_o | output | 3 | Power state: 0 Normal, 1 AutoHALT, 2 Stop-Grant, 3 Sleep, 4 Deep Sleep |
| l2_clk_en_o | output | 1 | L2 cache clock enable |
| snoop_en_o | output | 1 | Snoop-response enable |
| irq_latch_en_o | output | 1 | Interrupt-latch enable |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
The bench builds the block with `IDLE_LIMIT` = 8 and `REF_KHZ` = 200. With these values a stopped clock is detected within about a dozen cycles, and the 1 ms settling interval shrinks to 200 reference cycles. The full Deep Sleep round trip can then be observed on both sides of the settling boundary: Deep Sleep well before the count ends, Sleep shortly after it. The synchroniser depth and edge mode stay at their defaults (two stages, both edges).

// File: rtl/lps_pkg.sv
package lps_pkg;

   typedef enum logic [2:0] {
      PS_NORMAL   = 3'd0,
      PS_AUTOHALT = 3'd1,
      PS_STOPGNT  = 3'd2,
      PS_SLEEP    = 3'd3,
      PS_DEEP     = 3'd4,
      PS_SETTLE   = 3'd5
   } pstate_e;

   localparam logic [2:0] CODE_DEEP = 3'd4;

   typedef struct packed {
      logic stop;
      logic halt;
      logic sleep;
   } req_t;

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lps_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/lps_clk_monitor.sv
module lps_clk_monitor #(
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_LIMIT  = 64,
   parameter int EDGE_SEL    = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mon_clk_i,
   output logic running_o
);

   localparam int CW = $clog2(IDLE_LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

   generate
      if (IDLE_LIMIT < 2) begin : g_bad_limit
         $error("lps_clk_monitor: IDLE_LIMIT must be at least 2");
      end
      if (EDGE_SEL != 0 && EDGE_SEL != 1) begin : g_bad_edge
         $error("lps_clk_monitor: EDGE_SEL must be 0 or 1");
      end
   endgenerate

   logic          smp;
   logic          smp_d;
   logic          edge_seen;
   logic [CW-1:0] idle_q;

   lps_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (mon_clk_i),
      .q_o    (smp)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) smp_d <= 1'b0;
      else         smp_d <= smp;
   end

   generate
      if (EDGE_SEL == 0) begin : g_both
         assign edge_seen = smp ^ smp_d;
      end else begin : g_rise
         assign edge_seen = smp & ~smp_d;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         idle_q <= '0;
      else if (edge_seen)  idle_q <= '0;
      else if (idle_q != LIM) idle_q <= idle_q + 1'b1;
   end

   assign running_o = (idle_q < LIM);

   AST_EDGE_REVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_seen |=> running_o); // R6
   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!running_o && !edge_seen) |=> !running_o); // R5

endmodule

// File: rtl/lps_settle_timer.sv
module lps_settle_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic done_o
);

   localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("lps_settle_timer: CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (!run_i)        cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = run_i && (cnt_q == LAST);

   AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST); // R6
   AST_TMR_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
   import lps_pkg::*;
(
   input  logic    clk_i,
   input  logic    rst_ni,
   input  req_t    req_i,
   input  logic    bus_run_i,
   input  logic    irq_run_i,
   input  logic    settle_done_i,
   output logic    settle_run_o,
   output pstate_e state_o,
   output logic    viol_o
);

   pstate_e st_q, st_d;
   req_t    req_d;
   logic    viol_q, viol_set;
   logic    chg_stop, chg_halt, chg_sleep;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PS_NORMAL:   if (req_i.stop) st_d = PS_STOPGNT;
                      else if (req_i.halt) st_d = PS_AUTOHALT;
         PS_AUTOHALT: if (req_i.stop) st_d = PS_STOPGNT;
                      else if (!req_i.halt) st_d = PS_NORMAL;
         PS_STOPGNT:  if (!req_i.stop) st_d = PS_NORMAL;
                      else if (req_i.sleep) st_d = PS_SLEEP;
         PS_SLEEP:    if (!req_i.sleep) st_d = PS_STOPGNT;
                      else if (!bus_run_i) st_d = PS_DEEP;
         PS_DEEP:     if (bus_run_i) st_d = PS_SETTLE;
         PS_SETTLE:   if (!bus_run_i) st_d = PS_DEEP;
                      else if (settle_done_i) st_d = PS_SLEEP;
         default:     st_d = PS_NORMAL;
      endcase
   end

   assign chg_stop  = req_i.stop  ^ req_d.stop;
   assign chg_halt  = req_i.halt  ^ req_d.halt;
   assign chg_sleep = req_i.sleep ^ req_d.sleep;

   always_comb begin
      viol_set = 1'b0;
      unique case (st_q)
         PS_AUTOHALT, PS_STOPGNT: viol_set = !irq_run_i;
         PS_SLEEP:  viol_set = chg_stop | chg_halt;
         PS_DEEP:   viol_set = chg_stop | chg_halt | chg_sleep | (bus_run_i & !irq_run_i);
         PS_SETTLE: viol_set = chg_stop | chg_halt | chg_sleep;
         default:   viol_set = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= PS_NORMAL;
         req_d  <= '0;
         viol_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         req_d  <= req_i;
         viol_q <= viol_q | viol_set;
      end
   end

   assign settle_run_o = (st_q == PS_SETTLE);
   assign state_o      = st_q;
   assign viol_o       = viol_q;

   AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == PS_SLEEP && $past(st_q) != PS_SLEEP) |->
      ($past(st_q) == PS_STOPGNT || $past(st_q) == PS_SETTLE)); // R4
   AST_DEEP_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == PS_SLEEP && req_i.sleep && !bus_run_i) |=> (st_q == PS_DEEP)); // R5
   AST_SETTLE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == PS_SLEEP && $past(st_q) == PS_SETTLE) |-> $past(settle_done_i)); // R6
   AST_IRQCLK_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((st_q == PS_AUTOHALT || st_q == PS_STOPGNT) && !irq_run_i) |=> viol_q); // R7
   AST_RESTART_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == PS_DEEP && bus_run_i && !irq_run_i) |=> viol_q); // R10
   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol_q |=> viol_q); // R11

endmodule

// File: rtl/lps_sequencer.sv
module lps_sequencer
   import lps_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_LIMIT  = 64,
   parameter int EDGE_SEL    = 0,
   parameter int REF_KHZ     = 100000,
   parameter int SETTLE_US   = 1000
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       stop_req_i,
   input  logic       halt_i,
   input  logic       sleep_req_i,
   input  logic       bus_clk_i,
   input  logic       irq_clk_i,
   output logic [2:0] state_o,
   output logic       l2_clk_en_o,
   output logic       snoop_en_o,
   output logic       irq_latch_en_o,
   output logic       viol_o
);

   localparam int SETTLE_CYCLES = (REF_KHZ * SETTLE_US) / 1000;

   generate
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("lps_sequencer: settling interval rounds to zero cycles");
      end
   endgenerate

   logic [2:0] req_raw, req_sync;
   req_t       req;
   logic       bus_run, irq_run, settle_run, settle_done;
   pstate_e    st;

   assign req_raw = {stop_req_i, halt_i, sleep_req_i};

   lps_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_req_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (req_raw),
      .q_o    (req_sync)
   );

   assign req = req_t'(req_sync);

   lps_clk_monitor #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LIMIT(IDLE_LIMIT),
                     .EDGE_SEL(EDGE_SEL)) u_bus_mon (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mon_clk_i (bus_clk_i),
      .running_o (bus_run)
   );

   lps_clk_monitor #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LIMIT(IDLE_LIMIT),
                     .EDGE_SEL(EDGE_SEL)) u_irq_mon (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mon_clk_i (irq_clk_i),
      .running_o (irq_run)
   );

   lps_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (settle_run),
      .done_o (settle_done)
   );

   lps_fsm u_fsm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .req_i         (req),
      .bus_run_i     (bus_run),
      .irq_run_i     (irq_run),
      .settle_done_i (settle_done),
      .settle_run_o  (settle_run),
      .state_o       (st),
      .viol_o        (viol_o)
   );

   assign state_o        = (st == PS_SETTLE) ? CODE_DEEP : 3'(st);
   assign l2_clk_en_o    = !(st == PS_DEEP || st == PS_SETTLE);
   assign snoop_en_o     = !(st == PS_SLEEP || st == PS_DEEP || st == PS_SETTLE);
   assign irq_latch_en_o = snoop_en_o;

   AST_L2_HELD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!l2_clk_en_o && bus_run && !settle_done) |=> !l2_clk_en_o); // R6
   AST_SNOOP_ON_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o == 3'd1 || state_o == 3'd2) |-> (snoop_en_o && l2_clk_en_o)); // R3

endmodule

// File: tb/lps_sequencer_bench.sv
module lps_sequencer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_req = 1'b0, halt = 1'b0, sleep_req = 1'b0;
   logic       bus_clk = 1'b0, irq_clk = 1'b0;
   logic       bus_on = 1'b1, irq_on = 1'b1;
   logic       ph = 1'b0;
   logic [2:0] state;
   logic       l2_en, snoop_en, irq_en, viol;
   int         total = 0, bad = 0, cyc = 0;

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      ph <= ~ph;
      if (!bus_on) bus_clk <= 1'b0; else if (ph) bus_clk <= ~bus_clk;
      if (!irq_on) irq_clk <= 1'b0; else if (ph) irq_clk <= ~irq_clk;
   end

   lps_sequencer #(.IDLE_LIMIT(8), .REF_KHZ(200), .SETTLE_US(1000)) u_lps_sequencer (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .stop_req_i     (stop_req),
      .halt_i         (halt),
      .sleep_req_i    (sleep_req),
      .bus_clk_i      (bus_clk),
      .irq_clk_i      (irq_clk),
      .state_o        (state),
      .l2_clk_en_o    (l2_en),
      .snoop_en_o     (snoop_en),
      .irq_latch_en_o (irq_en),
      .viol_o         (viol)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      stop_req = 0; halt = 0; sleep_req = 0; bus_on = 1; irq_on = 1;
      rst_n = 0;
      wait_cyc(3);
      rst_n = 1;
      wait_cyc(4);
   endtask

   task automatic enter_sleep();
      stop_req = 1;  wait_cyc(6);
      sleep_req = 1; wait_cyc(6);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "state", state, 0);
      chk("R1", "enables", {l2_en, snoop_en, irq_en}, 3'b111);
      chk("R1", "flag", viol, 0);
   endtask

   task automatic t_halt();
      do_reset();
      halt = 1; wait_cyc(6);
      chk("R2", "state autohalt", state, 1);
      chk("R2", "enables autohalt", {l2_en, snoop_en, irq_en}, 3'b111);
      halt = 0; wait_cyc(6);
      chk("R2", "state back normal", state, 0);
   endtask

   task automatic t_stopgrant();
      do_reset();
      halt = 1; wait_cyc(6);
      stop_req = 1; wait_cyc(6);
      chk("R3", "state from autohalt", state, 2);
      chk("R3", "enables stopgrant", {l2_en, snoop_en, irq_en}, 3'b111);
      halt = 0; stop_req = 0; wait_cyc(6);
      chk("R3", "state back normal", state, 0);
      stop_req = 1; wait_cyc(6);
      chk("R3", "state from normal", state, 2);
      chk("R7", "flag quiet", viol, 0);
   endtask

   task automatic t_sleep();
      do_reset();
      enter_sleep();
      chk("R4", "state sleep", state, 3);
      chk("R4", "enables sleep", {l2_en, snoop_en, irq_en}, 3'b100);
      sleep_req = 0; wait_cyc(6);
      chk("R4", "state back stopgrant", state, 2);
      chk("R9", "legal exit no flag", viol, 0);
   endtask

   task automatic t_deep_round();
      do_reset();
      enter_sleep();
      irq_on = 0; wait_cyc(20);
      chk("R8", "irq clk off in sleep", viol, 0);
      bus_on = 0; wait_cyc(20);
      chk("R5", "state deep", state, 4);
      chk("R5", "enables deep", {l2_en, snoop_en, irq_en}, 3'b000);
      irq_on = 1; wait_cyc(10);
      bus_on = 1; wait_cyc(150);
      chk("R6", "still deep while settling", state, 4);
      chk("R6", "l2 off while settling", l2_en, 0);
      wait_cyc(80);
      chk("R6", "sleep after settling", state, 3);
      chk("R6", "l2 back on", l2_en, 1);
      chk("R8", "no flag over round trip", viol, 0);
   endtask

   task automatic t_irq_viol();
      do_reset();
      stop_req = 1; wait_cyc(6);
      irq_on = 0; wait_cyc(25);
      chk("R7", "irq clk off in stopgrant", viol, 1);
      irq_on = 1; stop_req = 0; wait_cyc(30);
      chk("R11", "flag sticky", viol, 1);
      do_reset();
      chk("R11", "reset clears flag", viol, 0);
   endtask

   task automatic t_deep_change();
      do_reset();
      enter_sleep();
      bus_on = 0; wait_cyc(20);
      chk("R9", "deep before change", viol, 0);
      halt = 1; wait_cyc(6);
      chk("R9", "halt change in deep", viol, 1);
      do_reset();
      enter_sleep();
      stop_req = 0; wait_cyc(6);
      chk("R9", "stop change in sleep", viol, 1);
   endtask

   task automatic t_restart_noirq();
      do_reset();
      enter_sleep();
      irq_on = 0; wait_cyc(20);
      bus_on = 0; wait_cyc(20);
      chk("R10", "before restart", viol, 0);
      bus_on = 1; wait_cyc(15);
      chk("R10", "restart without irq clk", viol, 1);
   endtask

   initial begin
      t_reset();
      t_halt();
      t_stopgrant();
      t_sleep();
      t_deep_round();
      t_irq_viol();
      t_deep_change();
      t_restart_noirq();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 100000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule